// File: doc/BRIEF.md
# Morse Letter Decoder

This block turns a stream of dot and dash key presses into ASCII characters. The two key inputs are level signals that are already synchronous to the clock. A rising edge on either key moves a two-level decoding tree down one branch. The block watches how long the keys stay silent. A short silence closes the current letter and releases its ASCII code. A longer silence releases one ASCII space, which marks a word boundary.

Each released character appears on `char_o` with a one-cycle `new_data_o` strobe. The character stays on `char_o` until the next release. A third symbol entered into an already complete two-symbol letter sets `err_o` and returns the tree to its root. Telling dots from dashes by press duration is done upstream of this block.

Top module: `morse_letter_dec`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `char_o` = 0x00, `new_data_o` = 0 and `err_o` = 0. The tree is at its root and the silence counter is stopped at zero.
- R2: Only a 0-to-1 transition of a key advances the tree. A key held high for many cycles counts as a single symbol.
- R3: From the root, a dash selects T (0x54) and a dot selects E (0x45).
- R4: From T, a dash gives M (0x4D) and a dot gives N (0x4E). From E, a dash gives A (0x41) and a dot gives I (0x49).
- R5: The silence counter rises by one per clock while both keys are low, and is cleared by any clock where a key is high. The letter window is counter values 16 to 30. In the first window cycle, a tree away from the root releases its letter and the tree returns to the root.
- R6: In the first cycle of the word window (counter values 31 to 49), the block releases 0x20.
- R7: `new_data_o` is never high for two cycles in a row. Each window releases at most once per silence period, and it may release again only after a key press.
- R8: When the tree is at its root during the first letter-window cycle, nothing is released.
- R9: A symbol that arrives when the tree holds a two-symbol letter sets `err_o` and returns the tree to the root. The next accepted symbol clears `err_o`.
- R10: When the silence counter reaches 50, it clears to zero and stops. It stays at zero, and nothing more is released, until the next key press.
- R11: A key press during silence restarts the count, so a pause shorter than the letter window leaves the letter open.
- R12: If dot and dash rise in the same cycle, the dash is taken (default `DASH_FIRST` = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_key | input | 1 | Dot key level |
| dash_key | input | 1 | Dash key level |
| char_o | output | 8 | Last released ASCII character |
| new_data_o | output | 1 | One-cycle strobe marking a release |
| err_o | output | 1 | Set when a symbol overflows the tree |

## Verification
The assertions assume that both key levels are already synchronous to `clk`. They also assume that `rst` is high at the first clock edge, so the checks that hold on the cycle after reset start from a known state. The stimulus changes the keys only on falling clock edges and holds each press for at least one cycle. It drives the two keys together only once, on purpose, to exercise the dash-first rule. It also includes silences that stop short of a window, stop inside one, and run past the counter limit.

// File: rtl/morse_pkg.sv
package morse_pkg;

   typedef enum logic [2:0] {
      ND_ROOT, ND_T, ND_E, ND_M, ND_N, ND_A, ND_I
   } node_t;

   localparam logic [7:0] ASCII_SPACE = 8'h20;

   function automatic logic [7:0] node_ascii(input node_t n);
      case (n)
         ND_T:    return 8'h54;
         ND_E:    return 8'h45;
         ND_M:    return 8'h4D;
         ND_N:    return 8'h4E;
         ND_A:    return 8'h41;
         ND_I:    return 8'h49;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic is_leaf(input node_t n);
      return (n == ND_M) || (n == ND_N) || (n == ND_A) || (n == ND_I);
   endfunction

   function automatic node_t child(input node_t n, input logic dash);
      case (n)
         ND_ROOT: return dash ? ND_T : ND_E;
         ND_T:    return dash ? ND_M : ND_N;
         ND_E:    return dash ? ND_A : ND_I;
         default: return ND_ROOT;
      endcase
   endfunction

endpackage

// File: rtl/morse_edge.sv
module morse_edge #(
   parameter int NKEYS = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NKEYS-1:0] lvl,
   output logic [NKEYS-1:0] rise
);

   if (NKEYS < 1) begin : g_bad_nkeys
      $error("morse_edge: NKEYS must be at least 1");
   end

   for (genvar k = 0; k < NKEYS; k++) begin : g_key
      logic prev_q;
      always_ff @(posedge clk) begin
         if (rst) prev_q <= 1'b0;
         else     prev_q <= lvl[k];
      end
      assign rise[k] = lvl[k] & ~prev_q;

      AST_EDGE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
         rise[k] |=> !rise[k]);   // R2
   end

endmodule

// File: rtl/morse_gap.sv
module morse_gap #(
   parameter int LETTER_LO = 15,
   parameter int WORD_LO   = 30,
   parameter int GAP_MAX   = 50
) (
   input  logic clk,
   input  logic rst,
   input  logic key_any,
   output logic letter_hit,
   output logic word_hit
);

   localparam int CW = $clog2(GAP_MAX + 1);
   localparam logic [CW-1:0] LLO_C = CW'(LETTER_LO);
   localparam logic [CW-1:0] WLO_C = CW'(WORD_LO);
   localparam logic [CW-1:0] MAX_C = CW'(GAP_MAX);

   if (!(LETTER_LO > 0 && LETTER_LO < WORD_LO && WORD_LO + 1 < GAP_MAX)) begin : g_bad_windows
      $error("morse_gap: need 0 < LETTER_LO < WORD_LO < GAP_MAX-1");
   end

   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic          ldone_q;
   logic          wdone_q;
   logic          in_letter;
   logic          in_word;

   assign in_letter  = !key_any && (cnt_q > LLO_C) && (cnt_q <= WLO_C);
   assign in_word    = !key_any && (cnt_q > WLO_C) && (cnt_q <  MAX_C);
   assign letter_hit = in_letter && !ldone_q;
   assign word_hit   = in_word   && !wdone_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         run_q   <= 1'b0;
         ldone_q <= 1'b0;
         wdone_q <= 1'b0;
      end else if (key_any) begin
         cnt_q   <= '0;
         run_q   <= 1'b1;
         ldone_q <= 1'b0;
         wdone_q <= 1'b0;
      end else begin
         if (letter_hit) ldone_q <= 1'b1;
         if (word_hit)   wdone_q <= 1'b1;
         if (run_q) begin
            if (cnt_q == MAX_C) begin
               cnt_q <= '0;
               run_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= MAX_C);                                   // R10
   AST_CNT_PARKED: assert property (@(posedge clk) disable iff (rst)
      (!run_q && !key_any) |=> (cnt_q == '0));           // R10
   AST_KEY_RESTARTS: assert property (@(posedge clk) disable iff (rst)
      key_any |=> (cnt_q == '0 && run_q));               // R11
   AST_LETTER_ONCE: assert property (@(posedge clk) disable iff (rst)
      letter_hit |=> !letter_hit);                       // R7

endmodule

// File: rtl/morse_tree.sv
module morse_tree
   import morse_pkg::*;
#(
   parameter bit DASH_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       dot_p,
   input  logic       dash_p,
   input  logic       letter_hit,
   input  logic       word_hit,
   output logic [7:0] char_o,
   output logic       new_data_o,
   output logic       err_o
);

   node_t node_q;
   logic  sym_v;
   logic  sel_dash;

   assign sym_v = dot_p | dash_p;

   if (DASH_FIRST) begin : g_dash_wins
      assign sel_dash = dash_p;
   end else begin : g_dot_wins
      assign sel_dash = dash_p & ~dot_p;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         node_q     <= ND_ROOT;
         char_o     <= 8'h00;
         new_data_o <= 1'b0;
         err_o      <= 1'b0;
      end else begin
         new_data_o <= 1'b0;
         if (sym_v) begin
            if (is_leaf(node_q)) begin
               err_o  <= 1'b1;
               node_q <= ND_ROOT;
            end else begin
               node_q <= child(node_q, sel_dash);
               err_o  <= 1'b0;
            end
         end else if (letter_hit) begin
            if (node_q != ND_ROOT) begin
               char_o     <= node_ascii(node_q);
               new_data_o <= 1'b1;
               node_q     <= ND_ROOT;
            end
         end else if (word_hit) begin
            char_o     <= ASCII_SPACE;
            new_data_o <= 1'b1;
         end
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (node_q == ND_ROOT && !new_data_o && !err_o && char_o == 8'h00)); // R1
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      new_data_o |=> !new_data_o);                                           // R7
   AST_OVERFLOW_ERR: assert property (@(posedge clk) disable iff (rst)
      (sym_v && is_leaf(node_q)) |=> (err_o && node_q == ND_ROOT));          // R9
   AST_ROOT_SILENT: assert property (@(posedge clk) disable iff (rst)
      (letter_hit && !sym_v && node_q == ND_ROOT) |=> !new_data_o);          // R8
   AST_SPACE_CODE: assert property (@(posedge clk) disable iff (rst)
      (word_hit && !sym_v && !letter_hit) |=> (new_data_o && char_o == 8'h20)); // R6

endmodule

// File: rtl/morse_letter_dec.sv
module morse_letter_dec #(
   parameter int LETTER_LO  = 15,
   parameter int WORD_LO    = 30,
   parameter int GAP_MAX    = 50,
   parameter bit DASH_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       dot_key,
   input  logic       dash_key,
   output logic [7:0] char_o,
   output logic       new_data_o,
   output logic       err_o
);

   localparam int NKEYS = 2;

   logic [NKEYS-1:0] rise;
   logic             letter_hit;
   logic             word_hit;
   logic             key_any;

   assign key_any = dot_key | dash_key;

   morse_edge #(.NKEYS(NKEYS)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  ({dash_key, dot_key}),
      .rise (rise)
   );

   morse_gap #(
      .LETTER_LO (LETTER_LO),
      .WORD_LO   (WORD_LO),
      .GAP_MAX   (GAP_MAX)
   ) u_gap (
      .clk        (clk),
      .rst        (rst),
      .key_any    (key_any),
      .letter_hit (letter_hit),
      .word_hit   (word_hit)
   );

   morse_tree #(.DASH_FIRST(DASH_FIRST)) u_tree (
      .clk        (clk),
      .rst        (rst),
      .dot_p      (rise[0]),
      .dash_p     (rise[1]),
      .letter_hit (letter_hit),
      .word_hit   (word_hit),
      .char_o     (char_o),
      .new_data_o (new_data_o),
      .err_o      (err_o)
   );

   AST_HELD_KEY_QUIET: assert property (@(posedge clk) disable iff (rst)
      ($past(dot_key) && dot_key && !dash_key) |-> !rise[0]);   // R2

endmodule

// File: tb/sim_morse_letter_dec.sv
`timescale 1ns/1ps
module sim_morse_letter_dec;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       dot_k = 1'b0;
   logic       dash_k = 1'b0;
   logic [7:0] char_o;
   logic       new_data_o;
   logic       err_o;

   always #5 clk = ~clk;

   morse_letter_dec u0 (
      .clk        (clk),
      .rst        (rst),
      .dot_key    (dot_k),
      .dash_key   (dash_k),
      .char_o     (char_o),
      .new_data_o (new_data_o),
      .err_o      (err_o)
   );

   // behavioural reference
   bit         path[$];          // 1 = dash
   int         m_cnt = 0;
   bit         m_run = 0, m_ld = 0, m_wd = 0, m_pd = 0, m_ph = 0;
   logic [7:0] m_ch = 8'h00;
   logic       m_nd = 1'b0, m_err = 1'b0;

   int    vectors = 0;
   int    fails   = 0;
   int    pulses  = 0;
   string tag     = "R1";

   function automatic logic [7:0] letter_of();
      if (path.size() == 1) return path[0] ? 8'h54 : 8'h45;
      case ({path[0], path[1]})
         2'b11:   return 8'h4D;
         2'b10:   return 8'h4E;
         2'b01:   return 8'h41;
         default: return 8'h49;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         path.delete();
         m_cnt = 0; m_run = 0; m_ld = 0; m_wd = 0; m_pd = 0; m_ph = 0;
         m_ch = 8'h00; m_nd = 1'b0; m_err = 1'b0;
      end else begin
         bit any, dp, hp, lw, ww;
         any = dot_k | dash_k;
         dp  = dot_k & !m_pd;
         hp  = dash_k & !m_ph;
         lw  = !any && m_cnt > 15 && m_cnt <= 30;
         ww  = !any && m_cnt > 30 && m_cnt < 50;
         m_nd = 1'b0;
         if (dp || hp) begin
            if (path.size() == 2) begin
               m_err = 1'b1;
               path.delete();
            end else begin
               path.push_back(hp);
               m_err = 1'b0;
            end
         end else if (lw && !m_ld) begin
            m_ld = 1;
            if (path.size() != 0) begin
               m_ch = letter_of();
               m_nd = 1'b1;
               path.delete();
            end
         end else if (ww && !m_wd) begin
            m_wd = 1;
            m_ch = 8'h20;
            m_nd = 1'b1;
         end
         if (any) begin
            m_cnt = 0; m_run = 1; m_ld = 0; m_wd = 0;
         end else if (m_run) begin
            if (m_cnt == 50) begin m_cnt = 0; m_run = 0; end
            else m_cnt = m_cnt + 1;
         end
         m_pd = dot_k;
         m_ph = dash_k;
      end
   end

   task automatic cyc(input logic d, input logic h);
      dot_k  = d;
      dash_k = h;
      @(negedge clk);
      vectors++;
      if (new_data_o === 1'b1) pulses++;
      if (char_o !== m_ch || new_data_o !== m_nd || err_o !== m_err) begin
         fails++;
         $display("FAIL %s: got ch=%h nd=%b err=%b, expected ch=%h nd=%b err=%b",
                  tag, char_o, new_data_o, err_o, m_ch, m_nd, m_err);
      end
   endtask

   task automatic sym(input bit dash, input int hold);
      for (int i = 0; i < hold; i++) cyc(!dash, dash);
      cyc(1'b0, 1'b0);
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
   endtask

   task automatic expect_pulses(input string t, input int exp);
      vectors++;
      if (pulses != exp) begin
         fails++;
         $display("FAIL %s: strobe count got %0d expected %0d", t, pulses, exp);
      end
      pulses = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      tag = "R1"; rst = 1'b1;
      cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b0);
      rst = 1'b0;
      quiet(60);                       // counter parked after reset
      pulses = 0;

      tag = "R3"; sym(1, 2); quiet(20);   // T
      tag = "R3"; sym(0, 1); quiet(20);   // E
      tag = "R4"; sym(1, 1); sym(1, 1); quiet(20);   // M
      tag = "R4"; sym(1, 1); sym(0, 1); quiet(20);   // N
      tag = "R4"; sym(0, 1); sym(1, 1); quiet(20);   // A
      tag = "R4"; sym(0, 1); sym(0, 1); quiet(20);   // I
      expect_pulses("R5", 6);

      tag = "R2"; sym(0, 12); quiet(20);  // long dot still E
      expect_pulses("R2", 1);

      tag = "R6"; sym(1, 1); quiet(70);   // T, space, then counter stops
      expect_pulses("R6", 2);
      tag = "R10"; quiet(120);
      expect_pulses("R10", 0);

      tag = "R11"; sym(0, 1); quiet(10); sym(1, 1); quiet(14); sym(0, 1); quiet(20);
      expect_pulses("R11", 0);            // three symbols: error, no letter
      tag = "R9"; sym(1, 1); quiet(20);   // clears error, T
      expect_pulses("R9", 1);

      tag = "R8"; sym(0, 1); sym(0, 1); sym(1, 1); quiet(40);
      expect_pulses("R8", 1);             // only the space

      tag = "R12"; cyc(1'b1, 1'b1); cyc(1'b0, 1'b0); quiet(20);
      expect_pulses("R12", 1);

      tag = "R7"; sym(1, 1); quiet(18); sym(0, 1); quiet(35);
      expect_pulses("R7", 3);

      tag = "R1"; rst = 1'b1; cyc(1'b0, 1'b0); rst = 1'b0; quiet(5);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule